// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This unit shifts a destination operand left or right by a count. The bit positions that the shift empties are refilled from a second operand, the fill source, and not with zeros or with bits rotated around. A left shift pulls in the most significant bits of the fill source. A right shift pulls in its least significant bits. The fill source is only read. Software chains several of these shifts to move data across several words, or to pack narrow fields into one word.

Operands are 32 or 16 bits wide. In 16-bit mode only the low halves of the operand ports are used. The unit also returns carry, parity, zero, sign and overflow flags. Its result and flags are held in an output register. A two-state control machine raises `out_valid` one cycle after each accepted request. The machine has two states. `ST_IDLE` moves to `ST_BUSY` when `in_valid` is high. `ST_BUSY` stays in `ST_BUSY` while `in_valid` stays high, and returns to `ST_IDLE` when `in_valid` is low.

Top module: `fsh_unit`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid`, `res_out`, `flags_out` and `cnt_bad` are all zero.
- R2: A request presented with `in_valid` high at a clock edge produces its result, with `out_valid` high, after that edge. `out_valid` is low after any edge where `in_valid` was low. Back-to-back requests give back-to-back results.
- R3: With `dir_right`=0 and count c, the result is the upper n bits of the 2n-bit value {dst, fill} shifted left by c. Here n is the operand width.
- R4: With `dir_right`=1 and count c, the result is the lower n bits of the 2n-bit value {fill, dst} shifted right by c.
- R5: With `wide`=0 (16-bit mode), only bits 15:0 of `dst_in` and `fill_in` are used, and bits 31:16 of `res_out` are zero. With `wide`=1, all 32 bits are used.
- R6: Only bits 4:0 of `cnt_in` form the count. Bits 7:5 have no effect.
- R7: A count of zero returns the destination unchanged, with `flags_out` equal to `flags_in` and `cnt_bad`=0.
- R8: In 16-bit mode, a count of 16 to 31 returns the destination unchanged, with `flags_out` equal to `flags_in` and `cnt_bad`=1. In every other case `cnt_bad` is 0.
- R9: For a valid nonzero count, carry (flag bit 0) is the last destination bit shifted out. That is dst[n-c] for a left shift and dst[c-1] for a right shift.
- R10: For a valid nonzero count, zero (flag bit 2) is set when the result is 0. Sign (flag bit 3) is the result's bit n-1. Parity (flag bit 1) is set when the result's low byte holds an even number of ones.
- R11: For a count of 1, overflow (flag bit 4) is set when the result's sign bit differs from the destination's sign bit. For a valid count of 2 or more, overflow is 0.
- R12: In 16-bit mode, three right shifts into a word that starts at zero pack a date. The shifts are by 7 with the year (0..99) as fill, then by 5 with the day (1..31), then by 4 with the month (1..12). The final word is month<<12 | day<<7 | year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| dir_right | input | 1 | 1 = shift right, 0 = shift left |
| wide | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| dst_in | input | 32 | Destination operand |
| fill_in | input | 32 | Fill source operand (read only) |
| cnt_in | input | 8 | Shift count; bits 4:0 are used |
| flags_in | input | 5 | Current flags {OF, SF, ZF, PF, CF} |
| out_valid | output | 1 | Result strobe |
| res_out | output | 32 | Shifted destination |
| flags_out | output | 5 | Updated flags {OF, SF, ZF, PF, CF} |
| cnt_bad | output | 1 | 16-bit request with a count above 15 |

## Verification
The assertions assume two things about the inputs. Operand, count and flag inputs are taken to be stable and meaningful whenever `in_valid` is high. `wide` is taken to select between exactly two operand sizes, so the properties on sign and upper-bit clearing read the previous cycle's `wide`. The stimulus respects this. It drives every input on the falling edge, sets `in_valid` only together with a fully defined request, and uses idle gaps only to exercise `out_valid` falling. Counts cover zero, one, the top legal value for each width, the illegal 16-bit range, and values with the ignored upper count bits set.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    localparam int FLG_W = 5;
    localparam int FLG_C = 0;
    localparam int FLG_P = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_S = 3;
    localparam int FLG_O = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } fsh_state_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic par;
        logic cry;
    } fsh_flags_t;

endpackage

// File: rtl/fsh_count_ctl.sv
module fsh_count_ctl #(
    parameter int XLEN     = 32,
    parameter int CNT_IN_W = 8,
    localparam int CNT_W   = $clog2(XLEN),
    localparam int HALF    = XLEN / 2
) (
    input  logic [CNT_IN_W-1:0] cnt_raw,
    input  logic                wide,
    output logic [CNT_W-1:0]    cnt,
    output logic                cnt_zero,
    output logic                cnt_ovr
);

    always_comb begin
        cnt      = cnt_raw[CNT_W-1:0];
        cnt_zero = (cnt == '0);
        cnt_ovr  = !wide && (int'(cnt) >= HALF);
    end

endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel #(
    parameter int XLEN   = 32,
    localparam int CNT_W = $clog2(XLEN),
    localparam int HALF  = XLEN / 2
) (
    input  logic              dir_right,
    input  logic              wide,
    input  logic [XLEN-1:0]   dst,
    input  logic [XLEN-1:0]   fill,
    input  logic [CNT_W-1:0]  cnt,
    output logic [XLEN-1:0]   res,
    output logic              carry
);

    logic [CNT_W-1:0] cnt_m1;
    assign cnt_m1 = cnt - 1'b1;

    // one funnel lane per operand size: lane 0 = half width, lane 1 = full width
    logic [XLEN-1:0] lane_res [2];
    logic            lane_cry [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 0) ? HALF : XLEN;
        logic [LW-1:0]   d_l;
        logic [LW-1:0]   f_l;
        logic [2*LW-1:0] cat_l;
        logic [2*LW-1:0] cat_r;
        logic [2*LW-1:0] sh_l;
        logic [2*LW-1:0] sh_r;
        logic [2*LW-1:0] pre_l;
        logic [2*LW-1:0] pre_r;

        always_comb begin
            d_l   = dst[LW-1:0];
            f_l   = fill[LW-1:0];
            cat_l = {d_l, f_l};
            cat_r = {f_l, d_l};
            sh_l  = cat_l << cnt;
            sh_r  = cat_r >> cnt;
            pre_l = cat_l << cnt_m1;
            pre_r = cat_r >> cnt_m1;
            lane_res[g] = '0;
            if (dir_right) begin
                lane_res[g][LW-1:0] = sh_r[LW-1:0];
                lane_cry[g]         = pre_r[0];
            end else begin
                lane_res[g][LW-1:0] = sh_l[2*LW-1:LW];
                lane_cry[g]         = pre_l[2*LW-1];
            end
        end
    end

    always_comb begin
        res   = wide ? lane_res[1] : lane_res[0];
        carry = wide ? lane_cry[1] : lane_cry[0];
    end

endmodule

// File: rtl/fsh_flags.sv
module fsh_flags
    import fsh_pkg::*;
#(
    parameter int XLEN   = 32,
    localparam int CNT_W = $clog2(XLEN),
    localparam int HALF  = XLEN / 2
) (
    input  logic              wide,
    input  logic [XLEN-1:0]   dst,
    input  logic [XLEN-1:0]   res,
    input  logic              carry,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              hold,
    input  fsh_flags_t        flg_in,
    output fsh_flags_t        flg_out
);

    logic res_msb;
    logic dst_msb;

    always_comb begin
        res_msb = wide ? res[XLEN-1] : res[HALF-1];
        dst_msb = wide ? dst[XLEN-1] : dst[HALF-1];
        if (hold) begin
            flg_out = flg_in;
        end else begin
            flg_out.cry = carry;
            flg_out.par = ~^res[7:0];
            flg_out.zro = (res == '0);
            flg_out.sgn = res_msb;
            flg_out.ovf = (cnt == CNT_W'(1)) ? (res_msb ^ dst_msb) : 1'b0;
        end
    end

endmodule

// File: rtl/fsh_unit.sv
module fsh_unit
    import fsh_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CNT_IN_W = 8,
    localparam int CNT_W   = $clog2(XLEN),
    localparam int HALF    = XLEN / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                dir_right,
    input  logic                wide,
    input  logic [XLEN-1:0]     dst_in,
    input  logic [XLEN-1:0]     fill_in,
    input  logic [CNT_IN_W-1:0] cnt_in,
    input  logic [FLG_W-1:0]    flags_in,
    output logic                out_valid,
    output logic [XLEN-1:0]     res_out,
    output logic [FLG_W-1:0]    flags_out,
    output logic                cnt_bad
);

    fsh_state_e state_q, state_d;

    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;
    logic             cnt_ovr;
    logic [XLEN-1:0]  dst_m;
    logic [XLEN-1:0]  fun_res;
    logic             fun_cry;
    logic [XLEN-1:0]  nxt_res;
    fsh_flags_t       flg_cur;
    fsh_flags_t       flg_nxt;

    fsh_count_ctl #(.XLEN(XLEN), .CNT_IN_W(CNT_IN_W)) u_cnt (
        .cnt_raw  (cnt_in),
        .wide     (wide),
        .cnt      (cnt),
        .cnt_zero (cnt_zero),
        .cnt_ovr  (cnt_ovr)
    );

    fsh_funnel #(.XLEN(XLEN)) u_fun (
        .dir_right (dir_right),
        .wide      (wide),
        .dst       (dst_in),
        .fill      (fill_in),
        .cnt       (cnt),
        .res       (fun_res),
        .carry     (fun_cry)
    );

    always_comb begin
        dst_m = wide ? dst_in : {{(XLEN-HALF){1'b0}}, dst_in[HALF-1:0]};
        flg_cur = fsh_flags_t'(flags_in);
        nxt_res = (cnt_zero || cnt_ovr) ? dst_m : fun_res;
    end

    fsh_flags #(.XLEN(XLEN)) u_flg (
        .wide    (wide),
        .dst     (dst_m),
        .res     (nxt_res),
        .carry   (fun_cry),
        .cnt     (cnt),
        .hold    (cnt_zero || cnt_ovr),
        .flg_in  (flg_cur),
        .flg_out (flg_nxt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_BUSY;
            ST_BUSY: if (!in_valid) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_out   <= '0;
            flags_out <= '0;
            cnt_bad   <= 1'b0;
        end else if (in_valid) begin
            res_out   <= nxt_res;
            flags_out <= flg_nxt;
            cnt_bad   <= cnt_ovr;
        end
    end

    assign out_valid = (state_q == ST_BUSY);

endmodule

// File: rtl/fsh_unit_chk.sv
module fsh_unit_chk #(
    parameter int XLEN     = 32,
    parameter int CNT_IN_W = 8,
    localparam int HALF    = XLEN / 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                dir_right,
    input logic                wide,
    input logic [XLEN-1:0]     dst_in,
    input logic [XLEN-1:0]     fill_in,
    input logic [CNT_IN_W-1:0] cnt_in,
    input logic [4:0]          flags_in,
    input logic                out_valid,
    input logic [XLEN-1:0]     res_out,
    input logic [4:0]          flags_out,
    input logic                cnt_bad
);

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_ZERO_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_in[4:0] == 5'd0) |=>
            (flags_out == $past(flags_in) && !cnt_bad &&
             res_out[HALF-1:0] == $past(dst_in[HALF-1:0]))); // R7

    AST_BAD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide && cnt_in[4]) |=>
            (cnt_bad && flags_out == $past(flags_in))); // R8

    AST_WIDE_NEVER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide) |=> !cnt_bad); // R8

    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (res_out[XLEN-1:HALF] == '0)); // R5

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_in[4:0] != 5'd0 && (wide || !cnt_in[4])) |=>
            (flags_out[2] == (res_out == '0))); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_in[4:0] > 5'd1 && (wide || !cnt_in[4])) |=>
            !flags_out[4]); // R11

endmodule

bind fsh_unit fsh_unit_chk #(.XLEN(XLEN), .CNT_IN_W(CNT_IN_W)) u_chk (.*);

// File: tb/sim_fsh_unit.sv
`timescale 1ns/1ps
module sim_fsh_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dir_right = 1'b0;
    logic        wide = 1'b0;
    logic [31:0] dst_in = '0;
    logic [31:0] fill_in = '0;
    logic [7:0]  cnt_in = '0;
    logic [4:0]  flags_in = '0;
    logic        out_valid;
    logic [31:0] res_out;
    logic [4:0]  flags_out;
    logic        cnt_bad;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    fsh_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_right(dir_right),
        .wide(wide), .dst_in(dst_in), .fill_in(fill_in), .cnt_in(cnt_in),
        .flags_in(flags_in), .out_valid(out_valid), .res_out(res_out),
        .flags_out(flags_out), .cnt_bad(cnt_bad)
    );

    // behavioural reference: 2n-bit concatenation and shift
    logic [31:0] e_res;
    logic [4:0]  e_flg;
    logic        e_bad;

    task automatic model(input bit rt, input bit wd, input logic [31:0] d,
                         input logic [31:0] f, input logic [7:0] ci,
                         input logic [4:0] fi);
        int n = wd ? 32 : 16;
        int c = int'(ci[4:0]);
        logic [63:0] msk = wd ? 64'hFFFF_FFFF : 64'hFFFF;
        logic [63:0] dd = {32'b0, d} & msk;
        logic [63:0] ff = {32'b0, f} & msk;
        logic [63:0] cat;
        logic cy, sg;
        e_bad = 1'b0;
        if (c == 0) begin
            e_res = dd[31:0]; e_flg = fi;
        end else if (n == 16 && c > 15) begin
            e_res = dd[31:0]; e_flg = fi; e_bad = 1'b1;
        end else begin
            if (!rt) begin
                cat = ((dd << n) | ff) << c;
                e_res = 32'((cat >> n) & msk);
                cy = dd[n - c];
            end else begin
                cat = ((ff << n) | dd) >> c;
                e_res = 32'(cat & msk);
                cy = dd[c - 1];
            end
            sg = e_res[n-1];
            e_flg[0] = cy;
            e_flg[1] = ~^e_res[7:0];
            e_flg[2] = (e_res == 0);
            e_flg[3] = sg;
            e_flg[4] = (c == 1) ? (sg ^ dd[n-1]) : 1'b0;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h, want %h", req, act, exp);
        end
    endtask

    // drive on falling edge, sample 5 ns after the capturing rising edge
    task automatic apply(input string req, input bit rt, input bit wd,
                         input logic [31:0] d, input logic [31:0] f,
                         input logic [7:0] ci, input logic [4:0] fi);
        @(negedge clk);
        in_valid = 1'b1; dir_right = rt; wide = wd;
        dst_in = d; fill_in = f; cnt_in = ci; flags_in = fi;
        model(rt, wd, d, f, ci, fi);
        @(posedge clk); #5;
        check({req, " valid"}, {31'b0, out_valid}, 32'd1);
        check({req, " result"}, res_out, e_res);
        check({req, " flags"}, {27'b0, flags_out}, {27'b0, e_flg});
        check({req, " cnt_bad"}, {31'b0, cnt_bad}, {31'b0, e_bad});
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #5;
        check("R2 idle valid", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin
        #50000000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        check("R1 valid", {31'b0, out_valid}, 0);
        check("R1 result", res_out, 0);
        check("R1 flags", {27'b0, flags_out}, 0);
        check("R1 cnt_bad", {31'b0, cnt_bad}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #5;
        check("R1 after release", {26'b0, out_valid, flags_out}, 0);

        // R3 left funnel, 32-bit
        apply("R3 left32", 0, 1, 32'h1234_5678, 32'hABCD_EF01, 8'd8, 5'h00);
        apply("R3 left32 max", 0, 1, 32'h8000_0001, 32'hFFFF_FFFF, 8'd31, 5'h1F);
        // R4 right funnel, 32-bit
        apply("R4 right32", 1, 1, 32'h1234_5678, 32'hABCD_EF01, 8'd12, 5'h00);
        apply("R4 right32 max", 1, 1, 32'h0000_0003, 32'h0000_0000, 8'd31, 5'h00);
        // R5 16-bit mode ignores upper operand halves
        apply("R5 left16", 0, 0, 32'hFFFF_00F0, 32'h5555_C000, 8'd4, 5'h00);
        apply("R5 right16 max", 1, 0, 32'hAAAA_8001, 32'hFFFF_0001, 8'd15, 5'h00);
        // R6 upper count bits ignored
        apply("R6 masked count", 0, 1, 32'h0F0F_0F0F, 32'hF000_0000, 8'hE3, 5'h00);
        apply("R6 masked zero", 1, 1, 32'hDEAD_BEEF, 32'h1111_1111, 8'hA0, 5'h15);
        idle();
        // R7 count zero holds destination and flags
        apply("R7 zero count", 0, 0, 32'h0000_1234, 32'hFFFF_FFFF, 8'd0, 5'h0B);
        // R8 illegal 16-bit count
        apply("R8 bad16", 0, 0, 32'h0000_8765, 32'h0000_4321, 8'd16, 5'h12);
        apply("R8 bad16 top", 1, 0, 32'h0000_0001, 32'h0000_FFFF, 8'd31, 5'h04);
        apply("R8 wide ok", 1, 1, 32'h0000_0001, 32'h0000_FFFF, 8'd16, 5'h04);
        // R9 carry, R10 flags, R11 overflow
        apply("R9 carry left", 0, 1, 32'h4000_0000, 32'h0, 8'd2, 5'h00);
        apply("R9 carry right", 1, 0, 32'h0000_0040, 32'h0, 8'd7, 5'h00);
        apply("R10 zero", 1, 1, 32'h0000_0001, 32'h0, 8'd1, 5'h00);
        apply("R10 sign parity", 0, 0, 32'h0000_4000, 32'h0000_8000, 8'd1, 5'h00);
        apply("R11 ovf one", 0, 1, 32'h4000_0000, 32'h0, 8'd1, 5'h00);
        apply("R11 no ovf", 0, 1, 32'h4000_0000, 32'h0, 8'd2, 5'h10);
        idle();
        idle();
        for (int i = 0; i < 60; i++) begin
            apply("R3 R4 sweep", i[0], i[1], 32'h9E37_79B9 * (i + 1),
                  32'h7F4A_7C15 ^ (i * 32'h0101_0101), 8'(i * 7), 5'(i));
        end
        // R12 date packing in 16-bit mode
        w = 32'h0;
        apply("R12 year", 1, 0, w, 32'd85, 8'd7, 5'h00);  w = res_out;
        apply("R12 day", 1, 0, w, 32'd17, 8'd5, 5'h00);   w = res_out;
        apply("R12 month", 1, 0, w, 32'd9, 8'd4, 5'h00);  w = res_out;
        check("R12 packed date", w, (32'd9 << 12) | (32'd17 << 7) | 32'd85);
        idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule